// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block raises an interrupt request toward the CPU after a programmed number of video scanlines. It watches address line A12 of the picture processor, which rises once per line while background and sprite patterns are fetched from different halves of pattern memory. Each qualified edge clocks a down-counter that reloads from a CPU-written latch. When the counter reaches zero and the interrupt is enabled, a sticky request is raised and held until the CPU acknowledges it.

A two-bit variant input selects one of three behaviours:
- **Late rising-edge variant:** counts on the rising edge of A12. A latch value of zero gives an interrupt on every line.
- **Early rising-edge variant:** counts on the rising edge. A latch value of zero suppresses the interrupt completely.
- **Falling-edge variant:** counts on the falling edge of A12, a few pixels later than the rising variants. A zero latch repeats every line, as in the late variant.

A12 edges are qualified against the CPU bus clock M2, so the rapid A12 toggles during sprite fetches are not counted. Everything runs in one system clock domain. All inputs are sampled on its rising edge, and a CPU write is a single-cycle strobe.

Top module: `scan_irq_top`

## Requirements
- R1: With variant 2'b00, 2'b01 or 2'b11 a qualified rising edge of A12 clocks the counter, so a due interrupt appears right after the rise. With variant 2'b10 only the falling edge that ends a qualified high period clocks it, and the rise alone raises nothing.
- R2: On each clocking edge the counter loads the latch if it is zero or a reload is pending, otherwise it decrements. After a reload, a nonzero latch N therefore raises the interrupt on every (N+1)-th counted line.
- R3: In the late variant (2'b00) a latch of zero raises the interrupt on every counted line.
- R4: In the early variant (2'b01) a latch of zero never raises the interrupt. With a nonzero latch, the interrupt is raised only when the counter reaches zero by decrementing.
- R5: In the falling-edge variant (2'b10) a latch of zero raises the interrupt on every counted line.
- R6: The CPU registers decode address bits 15:13 and bit 0 when the write strobe is high:
  - 110 even (0xC000) writes the latch from the data bus.
  - 110 odd (0xC001) requests a reload on the next clocking edge.
  - 111 even (0xE000) clears the pending interrupt and disables it.
  - 111 odd (0xE001) enables it.
- R7: Once raised, irq_o stays high across further counted lines until a disable write.
- R8: While disabled, the counter keeps running but no interrupt is raised.
- R9: A rising edge of A12 counts only if A12 was low for at least three falling edges of M2 beforehand. In the falling-edge variant, the following fall is ignored when the rise did not qualify.
- R10: Writes with address bits 15:13 outside 110 and 111 change neither the latch, the reload request nor the interrupt state.
- R11: After reset irq_o is low and the interrupt is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Variant select: 00 late, 01 early, 10 falling edge, 11 as 00 |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | CPU write strobe, one cycle per write |
| ppu_a12_i | input | 1 | Picture processor address line A12 |
| m2_i | input | 1 | CPU bus clock M2 |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The main function is swept over all three variants and latch values 0 to 4. Each run is several reload periods long, and the expected interrupt line is computed from the period N+1 or from the zero-latch rule. This separates the two zero-latch behaviours and shows off-by-one errors in the reload-versus-decrement choice. Each line is split into its rise and fall halves, which tells the rising variants apart from the falling one. Short low pulses of one and two M2 falls check the edge filter at its boundary. Writes to other address ranges, and runs without acknowledge or without enable, exercise the register decode, the sticky request and the enable gate.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  typedef enum logic [1:0] {
    MODE_LATE  = 2'b00,
    MODE_EARLY = 2'b01,
    MODE_FALL  = 2'b10,
    MODE_ALT   = 2'b11
  } irq_mode_e;

  typedef struct packed {
    logic fall_edge;
    logic zero_silent;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(irq_mode_e m);
    mode_cfg_t c;
    c.fall_edge   = (m == MODE_FALL);
    c.zero_silent = (m == MODE_EARLY);
    return c;
  endfunction
endpackage

// File: rtl/scan_irq_regs.sv
module scan_irq_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  data_i,
  input  logic              wr_i,
  output logic [CNT_W-1:0]  latch_o,
  output logic              reload_req_o,
  output logic              ack_o,
  output logic              irq_en_o
);
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_CNT = 3'b110;
  localparam logic [SEL_W-1:0] SEL_IRQ = 3'b111;

  logic [SEL_W-1:0] sel;
  logic odd, hit_cnt, hit_irq;

  assign sel     = addr_i[ADDR_W-1 -: SEL_W];
  assign odd     = addr_i[0];
  assign hit_cnt = wr_i && (sel == SEL_CNT);
  assign hit_irq = wr_i && (sel == SEL_IRQ);

  assign reload_req_o = hit_cnt && odd;
  assign ack_o        = hit_irq && !odd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o  <= '0;
      irq_en_o <= 1'b0;
    end else begin
      if (hit_cnt && !odd) latch_o <= data_i;
      if (ack_o) irq_en_o <= 1'b0;
      else if (hit_irq && odd) irq_en_o <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_irq_a12_filter.sv
module scan_irq_a12_filter #(
  parameter int LOW_M2 = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a12_i,
  input  logic m2_i,
  input  logic fall_edge_i,
  output logic tick_o
);
  localparam int LW = $clog2(LOW_M2 + 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(LOW_M2);

  logic a12_q, m2_q, armed;
  logic [LW-1:0] low_cnt;
  logic a12_rise, a12_fall, m2_fall, qual_rise;

  assign a12_rise  = a12_i && !a12_q;
  assign a12_fall  = !a12_i && a12_q;
  assign m2_fall   = !m2_i && m2_q;
  assign qual_rise = a12_rise && (low_cnt == LOW_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a12_q   <= 1'b0;
      m2_q    <= 1'b0;
      low_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      a12_q <= a12_i;
      m2_q  <= m2_i;
      if (a12_i) low_cnt <= '0;
      else if (m2_fall && low_cnt != LOW_MAX) low_cnt <= low_cnt + 1'b1;
      // armed marks a high period that began with a qualified rise
      if (qual_rise) armed <= 1'b1;
      else if (a12_fall) armed <= 1'b0;
    end
  end

  assign tick_o = fall_edge_i ? (a12_fall && armed) : qual_rise;
endmodule

// File: rtl/scan_irq_core.sv
module scan_irq_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             zero_silent_i,
  input  logic [CNT_W-1:0] latch_i,
  input  logic             reload_req_i,
  input  logic             ack_i,
  input  logic             irq_en_i,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt, cnt_next;
  logic reload_flag, load_path, fire, pending;

  assign load_path = (cnt == '0) || reload_flag;
  assign cnt_next  = load_path ? latch_i : cnt - 1'b1;
  // early variant: only a decrement reaching zero may fire
  assign fire = tick_i && irq_en_i && (cnt_next == '0) && (!zero_silent_i || !load_path);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt         <= '0;
      reload_flag <= 1'b0;
      pending     <= 1'b0;
    end else begin
      if (tick_i) begin
        cnt         <= cnt_next;
        reload_flag <= reload_req_i;
      end else if (reload_req_i) begin
        reload_flag <= 1'b1;
      end
      if (ack_i) pending <= 1'b0;
      else if (fire) pending <= 1'b1;
    end
  end

  assign irq_o = pending;
endmodule

// File: rtl/scan_irq_top.sv
module scan_irq_top #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8,
  parameter int LOW_M2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [CNT_W-1:0]  cpu_data_i,
  input  logic              cpu_wr_i,
  input  logic              ppu_a12_i,
  input  logic              m2_i,
  output logic              irq_o
);
  import scan_irq_pkg::*;

  mode_cfg_t cfg;
  logic [CNT_W-1:0] latch;
  logic reload_req, ack, irq_en, tick;

  assign cfg = decode_mode(irq_mode_e'(mode_i));

  scan_irq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(cpu_addr_i), .data_i(cpu_data_i), .wr_i(cpu_wr_i),
    .latch_o(latch), .reload_req_o(reload_req), .ack_o(ack), .irq_en_o(irq_en)
  );

  scan_irq_a12_filter #(.LOW_M2(LOW_M2)) u_filt (
    .clk_i, .rst_ni,
    .a12_i(ppu_a12_i), .m2_i(m2_i), .fall_edge_i(cfg.fall_edge), .tick_o(tick)
  );

  scan_irq_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .tick_i(tick), .zero_silent_i(cfg.zero_silent), .latch_i(latch),
    .reload_req_i(reload_req), .ack_i(ack), .irq_en_i(irq_en), .irq_o(irq_o)
  );
endmodule

// File: rtl/scan_irq_chk.sv
module scan_irq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_wr_i,
  input logic              ppu_a12_i,
  input logic              irq_en_i,
  input logic              irq_o
);
  logic ack_wr;
  assign ack_wr = cpu_wr_i && (cpu_addr_i[ADDR_W-1 -: 3] == 3'b111) && !cpu_addr_i[0];

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_wr |=> !irq_o); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_wr) |=> irq_o); // R7

  AST_EN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_i)); // R8

  AST_RISE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && $past(mode_i) != 2'b10) |-> ($past(ppu_a12_i) && !$past(ppu_a12_i, 2))); // R1

  AST_FALL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && $past(mode_i) == 2'b10) |-> (!$past(ppu_a12_i) && $past(ppu_a12_i, 2))); // R1
endmodule

bind scan_irq_top scan_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .cpu_addr_i(cpu_addr_i),
  .cpu_wr_i(cpu_wr_i), .ppu_a12_i(ppu_a12_i), .irq_en_i(irq_en), .irq_o(irq_o)
);

// File: tb/scan_irq_top_tb.sv
module scan_irq_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [15:0] addr = '0;
  logic [7:0] data = '0;
  logic wr = 1'b0;
  logic a12 = 1'b0;
  logic m2 = 1'b0;
  logic irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scan_irq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cpu_addr_i(addr),
    .cpu_data_i(data), .cpu_wr_i(wr), .ppu_a12_i(a12), .m2_i(m2), .irq_o(irq)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq_o=%0b expected %0b at %0t", req, irq, exp, $time);
    end
  endtask

  task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; data = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic line_rise(input int low_m2);
    @(negedge clk); a12 = 1'b0;
    for (int i = 0; i < low_m2; i++) begin
      m2 = 1'b1; @(negedge clk);
      m2 = 1'b0; @(negedge clk);
    end
    a12 = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic line_fall();
    a12 = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic line(input int low_m2);
    line_rise(low_m2);
    line_fall();
  endtask

  task automatic setup(input logic [1:0] m, input logic [7:0] lat);
    mode = m;
    cpu_wr(16'hC000, lat);
    cpu_wr(16'hC001, 8'h00);
    cpu_wr(16'hE000, 8'h00);
    cpu_wr(16'hE001, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset", 1'b0);
    // R11: disabled after reset, a zero latch in late mode raises nothing
    cpu_wr(16'hC000, 8'h00);
    cpu_wr(16'hC001, 8'h00);
    line(4); line(4);
    chk("R11 disabled after reset", 1'b0);

    // sweep: R2 period, R3/R4/R5 zero-latch rules
    for (int m = 0; m < 3; m++) begin
      for (int lat = 0; lat < 5; lat++) begin
        setup(2'(m), 8'(lat));
        for (int k = 1; k <= 2 * (lat + 1) + 1; k++) begin
          logic exp;
          string tag;
          line(4);
          if (lat == 0) begin
            exp = (m != 1);
            tag = (m == 1) ? "R4 early zero" : ((m == 2) ? "R5 falling zero" : "R3 late zero");
          end else begin
            exp = (k % (lat + 1) == 0);
            tag = "R2 period";
          end
          chk(tag, exp);
          if (irq) begin
            cpu_wr(16'hE000, 8'h00);
            cpu_wr(16'hE001, 8'h00);
          end
        end
      end
    end

    // R1: edge sense per variant
    setup(2'b10, 8'h00);
    line_rise(4); chk("R1 falling: quiet after rise", 1'b0);
    line_fall();  chk("R1 falling: set after fall", 1'b1);
    setup(2'b00, 8'h00);
    line_rise(4); chk("R1 late: set after rise", 1'b1);
    line_fall();
    setup(2'b11, 8'h00);
    line_rise(4); chk("R1 code 11 behaves as late", 1'b1);
    line_fall();

    // R7: sticky until disable write
    setup(2'b00, 8'h01);
    line(4); line(4); chk("R7 raised", 1'b1);
    line(4); line(4); chk("R7 held without ack", 1'b1);
    cpu_wr(16'hE000, 8'h00);
    chk("R6 ack clears", 1'b0);

    // R8: disabled counter raises nothing
    line(4); line(4); line(4); line(4);
    chk("R8 disabled", 1'b0);

    // R9: short low periods not counted
    for (int m = 0; m < 3; m += 2) begin
      setup(2'(m), 8'h01);
      line(4);              // reload to 1
      line(1); chk("R9 one M2 fall ignored", 1'b0);
      line(2); chk("R9 two M2 falls ignored", 1'b0);
      line(3); chk("R9 three M2 falls counted", 1'b1);
    end

    // R10: out-of-range writes ignored; R6: decode of the odd latch address
    setup(2'b00, 8'h02);
    cpu_wr(16'hA000, 8'h00);
    cpu_wr(16'h8001, 8'h00);
    cpu_wr(16'h6000, 8'h00);
    line(4); chk("R10 latch kept", 1'b0);
    line(4); chk("R10 no early fire", 1'b0);
    line(4); chk("R10 period 3 kept", 1'b1);
    cpu_wr(16'h0000, 8'h00);
    chk("R10 foreign write keeps irq", 1'b1);
    cpu_wr(16'hE000, 8'h00);
    chk("R6 ack at 0xE000", 1'b0);
    cpu_wr(16'hFFFF, 8'h00);   // enable via odd 111 address
    cpu_wr(16'hDFFE, 8'h00);   // latch 0 via even 110 address
    cpu_wr(16'hC003, 8'h00);   // reload
    line(4); chk("R6 mirrored decode", 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule